// File: doc/BRIEF.md
# NAND ECC Engine Register and Interrupt Front End

This block is the software-facing control surface of a NAND page error-correction engine with an encode channel and a decode channel. A simple 32-bit register bus writes the start/stop control, configuration words and the source address, and reads back idle flags, the encoder's parity words and a per-sector decode-done bitmap. The BCH codec itself sits outside; it sees only a run level and decoded configuration fields per channel, and it answers with a busy level, done pulses (with a last-of-page flag and, for decode, a sector number) and parity words.

Each channel has an interrupt enable register and an interrupt status register that clears when read. The clear is honoured only while that channel's interrupt enable is set, so a status raised with interrupts masked stays pending. A completion that arrives in the same cycle as a clearing read survives the read, so the interrupt fires again. Because several sector completions can merge into one interrupt, the decode-done bitmap lets software see every finished sector.

Top module: `ecc_ctl_regs`

## Requirements
- R1: After reset both control registers, both configuration registers, the address register, both interrupt enables, both statuses and the sector bitmap are 0, both idle registers read 1, and `irq` is 0.
- R2: Writing 1 in bit 0 of a control register (encoder 0x000, decoder 0x100) raises that channel's run output; writing 0 drops it. The idle register (encoder 0x00C, decoder 0x10C) reads 1 in bit 0 unless the channel is running and its codec reports busy.
- R3: Configuration words (encoder 0x004, decoder 0x104) and the encoder address (0x008) read back as written; each configuration word drives a strength index from bits MODE_SHIFT-1:0, a mode from the MODE_W bits starting at MODE_SHIFT, and a message size in bits from bits 30:16.
- R4: The decoder configuration also drives a correction-enable field from bits 13:12 and an empty-page detect enable from bit 31.
- R5: In an interrupt enable register (encoder 0x080, decoder 0x200), bit 0 gates the interrupt and bit 1 selects page mode; in page mode only a done pulse carrying the last flag sets status, otherwise every done pulse does. Done pulses have no effect while the channel is stopped.
- R6: Reading a status register (encoder 0x084, decoder 0x204) returns the status in bit 0 on the next cycle and clears it, provided the channel's enable bit 0 is set.
- R7: A status read while enable bit 0 is clear returns the status and leaves it set.
- R8: A done pulse in the same cycle as a clearing status read leaves the status set after the read.
- R9: `irq` is high exactly when (encoder status and encoder enable bit 0) or (decoder status and decoder enable bit 0).
- R10: While the decoder runs, a decode done pulse for sector n sets bit n of the bitmap at 0x124, whatever the page-mode setting; bits stay set until cleared.
- R11: Writing 0 to the decoder control register clears the bitmap and makes the decoder idle.
- R12: A parity word latched from the codec at index i reads back at 0x010 + 4*i.
- R13: A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| enc_run | output | 1 | Encoder enabled |
| enc_busy | input | 1 | Encoder codec busy |
| enc_done | input | 1 | Encoder done pulse |
| enc_last | input | 1 | Encoder pulse ends the page |
| dec_run | output | 1 | Decoder enabled |
| dec_busy | input | 1 | Decoder codec busy |
| dec_done | input | 1 | Decoder sector done pulse |
| dec_last | input | 1 | Decoder pulse ends the page |
| dec_sector | input | SECT_W | Sector number of the done pulse |
| par_we | input | 1 | Parity word valid |
| par_idx | input | PIDX_W | Parity word index |
| par_word | input | 32 | Parity word |
| enc_strength | output | MODE_SHIFT | Encoder strength index |
| enc_mode | output | MODE_W | Encoder mode |
| enc_msg_bits | output | 15 | Encoder message size in bits |
| enc_dma_addr | output | 32 | Encoder source address |
| dec_strength | output | MODE_SHIFT | Decoder strength index |
| dec_mode | output | MODE_W | Decoder mode |
| dec_msg_bits | output | 15 | Decoder message size in bits |
| dec_correct | output | 2 | Decoder correction enable field |
| dec_empty_en | output | 1 | Decoder empty-page detect enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the read-to-clear rules: a read with the enable bit clear must leave the status pending (a design that clears anyway loses the interrupt once software unmasks it), and a sector finishing in the very cycle of a clearing read must keep the status set (a design that lets the clear win drops the last sector's interrupt and software waits forever). Page mode is tested with a non-last pulse that must set the bitmap bit but not the status, which catches a design that raises the interrupt per sector or skips the bitmap. Stopping the decoder must empty the bitmap and force idle with the codec still busy, and a pulse while stopped must change nothing visible.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned MSG_LSB = 16;
    localparam int unsigned MSG_W = 15;

    localparam logic [ADDR_W-1:0] A_ENC_CTL  = 12'h000;
    localparam logic [ADDR_W-1:0] A_ENC_CFG  = 12'h004;
    localparam logic [ADDR_W-1:0] A_ENC_ADDR = 12'h008;
    localparam logic [ADDR_W-1:0] A_ENC_IDLE = 12'h00C;
    localparam logic [ADDR_W-1:0] A_PAR_BASE = 12'h010;
    localparam logic [ADDR_W-1:0] A_ENC_IE   = 12'h080;
    localparam logic [ADDR_W-1:0] A_ENC_IS   = 12'h084;
    localparam logic [ADDR_W-1:0] A_DEC_CTL  = 12'h100;
    localparam logic [ADDR_W-1:0] A_DEC_CFG  = 12'h104;
    localparam logic [ADDR_W-1:0] A_DEC_IDLE = 12'h10C;
    localparam logic [ADDR_W-1:0] A_DEC_MAP  = 12'h124;
    localparam logic [ADDR_W-1:0] A_DEC_IE   = 12'h200;
    localparam logic [ADDR_W-1:0] A_DEC_IS   = 12'h204;

    localparam int unsigned CH_ENC = 0;
    localparam int unsigned CH_DEC = 1;

    // bit 1: one status per page, bit 0: interrupt gate
    typedef struct packed {
        logic page_mode;
        logic en;
    } irq_en_t;

    function automatic logic word_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] target);
        return a[ADDR_W-1:2] == target[ADDR_W-1:2];
    endfunction
endpackage

// File: rtl/ecc_irq_chan.sv
module ecc_irq_chan
    import ecc_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ie_we,
    input  logic [1:0] ie_wdata,
    input  logic       rd_stat,
    input  logic       ev_pulse,
    input  logic       ev_last,
    input  logic       run,
    output irq_en_t    ie,
    output logic       status,
    output logic       irq
);
    logic set_evt;

    assign set_evt = run && ev_pulse && (!ie.page_mode || ev_last);
    assign irq     = status && ie.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie     <= '0;
            status <= 1'b0;
        end else begin
            if (ie_we)
                ie <= irq_en_t'(ie_wdata);
            if (rd_stat && ie.en)
                status <= set_evt;
            else
                status <= status || set_evt;
        end
    end

    p_set_survives_r8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> status);
    p_masked_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !ie.en && status) |=> status);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && ie.en && !set_evt) |=> !status);
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!run && !status && !(rd_stat && ie.en)) |=> !status);
endmodule

// File: rtl/ecc_sector_map.sv
module ecc_sector_map #(
    parameter int unsigned N_SECT = 16,
    localparam int unsigned SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set_en,
    input  logic [SECT_W-1:0] idx,
    output logic [N_SECT-1:0] map
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            map <= '0;
        else if (set_en && (int'(idx) < N_SECT))
            map[idx] <= 1'b1;
    end

    p_map_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (map == '0));
    p_map_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((map & $past(map)) == $past(map)));
endmodule

// File: rtl/ecc_parity_win.sv
module ecc_parity_win #(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [31:0]      w_data,
    input  logic [IDX_W-1:0] r_idx,
    output logic [31:0]      r_data
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '0;
        end else if (we && (int'(w_idx) < WORDS)) begin
            mem[w_idx] <= w_data;
        end
    end

    assign r_data = (int'(r_idx) < WORDS) ? mem[r_idx] : '0;

    p_par_latch_r12: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(w_idx) < WORDS)) |=> (mem[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_regs_pkg::*;
#(
    parameter int unsigned MODE_SHIFT = 5,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned N_SECT     = 16,
    parameter int unsigned PAR_WORDS  = 16,
    localparam int unsigned SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1,
    localparam int unsigned PIDX_W = (PAR_WORDS > 1) ? $clog2(PAR_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  enc_run,
    input  logic                  enc_busy,
    input  logic                  enc_done,
    input  logic                  enc_last,
    output logic                  dec_run,
    input  logic                  dec_busy,
    input  logic                  dec_done,
    input  logic                  dec_last,
    input  logic [SECT_W-1:0]     dec_sector,
    input  logic                  par_we,
    input  logic [PIDX_W-1:0]     par_idx,
    input  logic [31:0]           par_word,
    output logic [MODE_SHIFT-1:0] enc_strength,
    output logic [MODE_W-1:0]     enc_mode,
    output logic [14:0]           enc_msg_bits,
    output logic [31:0]           enc_dma_addr,
    output logic [MODE_SHIFT-1:0] dec_strength,
    output logic [MODE_W-1:0]     dec_mode,
    output logic [14:0]           dec_msg_bits,
    output logic [1:0]            dec_correct,
    output logic                  dec_empty_en,
    output logic                  irq
);
    localparam int unsigned PAR_SPAN = 4 * PAR_WORDS;

    logic [31:0] enc_cfg, dec_cfg, enc_addr_q;
    logic        enc_ctl, dec_ctl;
    logic        dec_stop;
    logic [N_SECT-1:0] sect_map;
    logic [31:0] par_rd;
    logic [PIDX_W-1:0] par_ridx;
    logic        par_hit;
    logic [11:0] par_off;

    logic    ch_ie_we [2];
    logic    ch_rd    [2];
    logic    ch_pulse [2];
    logic    ch_last  [2];
    logic    ch_run   [2];
    irq_en_t ch_ie    [2];
    logic    ch_stat  [2];
    logic    ch_irq   [2];

    assign dec_stop = bus_wr && word_hit(bus_addr, A_DEC_CTL) && !bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_ctl    <= 1'b0;
            dec_ctl    <= 1'b0;
            enc_cfg    <= '0;
            dec_cfg    <= '0;
            enc_addr_q <= '0;
        end else if (bus_wr) begin
            if (word_hit(bus_addr, A_ENC_CTL))  enc_ctl    <= bus_wdata[0];
            if (word_hit(bus_addr, A_DEC_CTL))  dec_ctl    <= bus_wdata[0];
            if (word_hit(bus_addr, A_ENC_CFG))  enc_cfg    <= bus_wdata;
            if (word_hit(bus_addr, A_DEC_CFG))  dec_cfg    <= bus_wdata;
            if (word_hit(bus_addr, A_ENC_ADDR)) enc_addr_q <= bus_wdata;
        end
    end

    assign enc_run      = enc_ctl;
    assign dec_run      = dec_ctl;
    assign enc_dma_addr = enc_addr_q;
    assign enc_strength = enc_cfg[MODE_SHIFT-1:0];
    assign enc_mode     = enc_cfg[MODE_SHIFT +: MODE_W];
    assign enc_msg_bits = enc_cfg[MSG_LSB +: MSG_W];
    assign dec_strength = dec_cfg[MODE_SHIFT-1:0];
    assign dec_mode     = dec_cfg[MODE_SHIFT +: MODE_W];
    assign dec_msg_bits = dec_cfg[MSG_LSB +: MSG_W];
    assign dec_correct  = dec_cfg[13:12];
    assign dec_empty_en = dec_cfg[31];

    // channel wiring, index CH_ENC / CH_DEC
    assign ch_ie_we[CH_ENC] = bus_wr && word_hit(bus_addr, A_ENC_IE);
    assign ch_ie_we[CH_DEC] = bus_wr && word_hit(bus_addr, A_DEC_IE);
    assign ch_rd[CH_ENC]    = bus_rd && word_hit(bus_addr, A_ENC_IS);
    assign ch_rd[CH_DEC]    = bus_rd && word_hit(bus_addr, A_DEC_IS);
    assign ch_pulse[CH_ENC] = enc_done;
    assign ch_pulse[CH_DEC] = dec_done;
    assign ch_last[CH_ENC]  = enc_last;
    assign ch_last[CH_DEC]  = dec_last;
    assign ch_run[CH_ENC]   = enc_ctl;
    assign ch_run[CH_DEC]   = dec_ctl;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        ecc_irq_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .ie_we    (ch_ie_we[c]),
            .ie_wdata (bus_wdata[1:0]),
            .rd_stat  (ch_rd[c]),
            .ev_pulse (ch_pulse[c]),
            .ev_last  (ch_last[c]),
            .run      (ch_run[c]),
            .ie       (ch_ie[c]),
            .status   (ch_stat[c]),
            .irq      (ch_irq[c])
        );
    end

    assign irq = ch_irq[CH_ENC] || ch_irq[CH_DEC];

    ecc_sector_map #(.N_SECT(N_SECT)) u_map (
        .clk    (clk),
        .rst    (rst),
        .clr    (dec_stop),
        .set_en (dec_ctl && dec_done),
        .idx    (dec_sector),
        .map    (sect_map)
    );

    assign par_off  = bus_addr - A_PAR_BASE;
    assign par_hit  = (bus_addr >= A_PAR_BASE) && (int'(par_off) < PAR_SPAN);
    assign par_ridx = par_off[PIDX_W+1:2];

    ecc_parity_win #(.WORDS(PAR_WORDS)) u_par (
        .clk    (clk),
        .rst    (rst),
        .we     (par_we),
        .w_idx  (par_idx),
        .w_data (par_word),
        .r_idx  (par_ridx),
        .r_data (par_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= '0;
            if (par_hit)                            bus_rdata <= par_rd;
            else if (word_hit(bus_addr, A_ENC_CTL))  bus_rdata <= {31'd0, enc_ctl};
            else if (word_hit(bus_addr, A_ENC_CFG))  bus_rdata <= enc_cfg;
            else if (word_hit(bus_addr, A_ENC_ADDR)) bus_rdata <= enc_addr_q;
            else if (word_hit(bus_addr, A_ENC_IDLE)) bus_rdata <= {31'd0, !(enc_ctl && enc_busy)};
            else if (word_hit(bus_addr, A_ENC_IE))   bus_rdata <= {30'd0, ch_ie[CH_ENC]};
            else if (word_hit(bus_addr, A_ENC_IS))   bus_rdata <= {31'd0, ch_stat[CH_ENC]};
            else if (word_hit(bus_addr, A_DEC_CTL))  bus_rdata <= {31'd0, dec_ctl};
            else if (word_hit(bus_addr, A_DEC_CFG))  bus_rdata <= dec_cfg;
            else if (word_hit(bus_addr, A_DEC_IDLE)) bus_rdata <= {31'd0, !(dec_ctl && dec_busy)};
            else if (word_hit(bus_addr, A_DEC_MAP))  bus_rdata <= 32'(sect_map);
            else if (word_hit(bus_addr, A_DEC_IE))   bus_rdata <= {30'd0, ch_ie[CH_DEC]};
            else if (word_hit(bus_addr, A_DEC_IS))   bus_rdata <= {31'd0, ch_stat[CH_DEC]};
        end
    end

    initial begin
        if (MODE_SHIFT + MODE_W > 12)
            $error("mode field overlaps correction field");
    end

    p_stop_drops_run_r11: assert property (@(posedge clk) disable iff (rst)
        dec_stop |=> !dec_run);
    p_start_raises_run_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && word_hit(bus_addr, A_ENC_CTL) && bus_wdata[0]) |=> enc_run);
    p_irq_needs_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ch_ie[CH_ENC].en || ch_ie[CH_DEC].en));
endmodule

// File: tb/sim_ecc_ctl_regs.sv
module sim_ecc_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        enc_run, dec_run;
    logic        enc_busy = 0, enc_done = 0, enc_last = 0;
    logic        dec_busy = 0, dec_done = 0, dec_last = 0;
    logic [3:0]  dec_sector = '0;
    logic        par_we = 0;
    logic [3:0]  par_idx = '0;
    logic [31:0] par_word = '0;
    logic [4:0]  enc_strength, dec_strength;
    logic [1:0]  enc_mode, dec_mode, dec_correct;
    logic [14:0] enc_msg_bits, dec_msg_bits;
    logic [31:0] enc_dma_addr;
    logic        dec_empty_en, irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecc_ctl_regs u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_run(enc_run), .enc_busy(enc_busy), .enc_done(enc_done), .enc_last(enc_last),
        .dec_run(dec_run), .dec_busy(dec_busy), .dec_done(dec_done), .dec_last(dec_last),
        .dec_sector(dec_sector), .par_we(par_we), .par_idx(par_idx), .par_word(par_word),
        .enc_strength(enc_strength), .enc_mode(enc_mode), .enc_msg_bits(enc_msg_bits),
        .enc_dma_addr(enc_dma_addr), .dec_strength(dec_strength), .dec_mode(dec_mode),
        .dec_msg_bits(dec_msg_bits), .dec_correct(dec_correct),
        .dec_empty_en(dec_empty_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic dec_pulse(input logic [3:0] s, input logic last);
        @(negedge clk);
        dec_done = 1; dec_sector = s; dec_last = last;
        @(negedge clk);
        dec_done = 0; dec_last = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        rd(12'h000, v); chk("R1 enc ctl", v, 0);
        rd(12'h00C, v); chk("R1 enc idle", v, 1);
        rd(12'h10C, v); chk("R1 dec idle", v, 1);
        rd(12'h124, v); chk("R1 bitmap", v, 0);
        rd(12'h204, v); chk("R1 dec status", v, 0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        // 512 bytes, strength 24 at 14 bits -> 4096+336 = 4432 bits
        wr(12'h004, (32'd4096 << 16) | (32'd1 << 5) | 32'd10);
        chk("R3 enc strength", 32'(enc_strength), 10);
        chk("R3 enc mode", 32'(enc_mode), 1);
        chk("R3 enc msg", 32'(enc_msg_bits), 4096);
        wr(12'h104, (32'd1 << 31) | (32'd4432 << 16) | (32'd3 << 12) | (32'd2 << 5) | 32'd10);
        chk("R3 dec msg", 32'(dec_msg_bits), 4432);
        chk("R3 dec mode", 32'(dec_mode), 2);
        chk("R4 dec correct", 32'(dec_correct), 3);
        chk("R4 dec empty", 32'(dec_empty_en), 1);
        wr(12'h008, 32'h8000_1240);
        chk("R3 dma addr", enc_dma_addr, 32'h8000_1240);
        rd(12'h104, v); chk("R3 dec cfg readback", v, (32'd1 << 31) | (32'd4432 << 16) | (32'd3 << 12) | (32'd2 << 5) | 32'd10);
    endtask

    task automatic t_ctl_idle;
        logic [31:0] v;
        enc_busy = 1;
        wr(12'h000, 1);
        chk("R2 enc run", 32'(enc_run), 1);
        rd(12'h00C, v); chk("R2 idle while busy", v, 0);
        enc_busy = 0;
        rd(12'h00C, v); chk("R2 idle after busy", v, 1);
        wr(12'h000, 0);
        chk("R2 enc stop", 32'(enc_run), 0);
    endtask

    task automatic t_per_sector;
        logic [31:0] v;
        wr(12'h200, 1);
        wr(12'h100, 1);
        chk("R2 dec run", 32'(dec_run), 1);
        dec_pulse(0, 0);
        chk("R9 irq on sector", 32'(irq), 1);
        rd(12'h204, v); chk("R6 status read", v, 1);
        chk("R6 irq after clear", 32'(irq), 0);
        rd(12'h204, v); chk("R6 status cleared", v, 0);
        dec_pulse(3, 0);
        rd(12'h124, v); chk("R10 bitmap", v, 32'h9);
        rd(12'h204, v); chk("R6 second sector", v, 1);
    endtask

    task automatic t_page_mode;
        logic [31:0] v;
        wr(12'h200, 3);
        dec_pulse(4, 0);
        chk("R5 no irq mid page", 32'(irq), 0);
        rd(12'h124, v); chk("R10 bitmap page mode", v, 32'h19);
        dec_pulse(5, 1);
        chk("R5 irq at last", 32'(irq), 1);
        rd(12'h204, v); chk("R5 status last", v, 1);
        wr(12'h200, 1);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        wr(12'h080, 0);
        wr(12'h000, 1);
        @(negedge clk); enc_done = 1; enc_last = 1;
        @(negedge clk); enc_done = 0; enc_last = 0;
        chk("R9 masked no irq", 32'(irq), 0);
        rd(12'h084, v); chk("R7 masked read", v, 1);
        rd(12'h084, v); chk("R7 still pending", v, 1);
        wr(12'h080, 1);
        chk("R9 unmask irq", 32'(irq), 1);
        rd(12'h084, v); chk("R6 enc read", v, 1);
        rd(12'h084, v); chk("R6 enc cleared", v, 0);
        wr(12'h000, 0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        // status is clear, enable set, decoder running
        @(negedge clk);
        bus_rd = 1; bus_addr = 12'h204;
        dec_done = 1; dec_sector = 6; dec_last = 0;
        @(negedge clk);
        bus_rd = 0; dec_done = 0;
        chk("R8 read value", bus_rdata, 0);
        chk("R8 irq kept", 32'(irq), 1);
        rd(12'h204, v); chk("R8 status kept", v, 1);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        dec_busy = 1;
        rd(12'h10C, v); chk("R2 dec busy idle", v, 0);
        wr(12'h100, 0);
        rd(12'h124, v); chk("R11 bitmap cleared", v, 0);
        rd(12'h10C, v); chk("R11 idle after stop", v, 1);
        dec_pulse(2, 1);
        rd(12'h124, v); chk("R10 stopped bitmap", v, 0);
        chk("R5 stopped no irq", 32'(irq), 0);
        rd(12'h204, v); chk("R5 stopped status", v, 0);
        dec_busy = 0;
    endtask

    task automatic t_parity;
        logic [31:0] v;
        @(negedge clk); par_we = 1; par_idx = 0; par_word = 32'hA5A5_0001;
        @(negedge clk); par_idx = 15; par_word = 32'h1234_5678;
        @(negedge clk); par_we = 0;
        rd(12'h010, v); chk("R12 parity 0", v, 32'hA5A5_0001);
        rd(12'h04C, v); chk("R12 parity 15", v, 32'h1234_5678);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd(12'h050, v); chk("R13 gap", v, 0);
        rd(12'h300, v); chk("R13 high", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_config();
        t_ctl_idle();
        t_per_sector();
        t_page_mode();
        t_masked();
        t_race();
        t_stop();
        t_parity();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule